// File: doc/BRIEF.md
# SPI Register-Mapped GPIO Expander

This block is an SPI target (mode 0: idle-low clock, data sampled on the rising edge and changed on the falling edge, most significant bit first). It presents an 8-pin general-purpose port to a host through a set of byte-wide control registers. Each transfer, framed by an active-low select, opens with a control byte. That byte carries a fixed four-bit prefix `0100`, a three-bit device address in bits 3:1 and a direction flag in bit 0 (1 = read, 0 = write). A register address byte follows. After it, the host either sends data bytes to be stored or clocks out register contents. Several expanders may share one select line. When the address-enable bit of the configuration register is set, a device joins a transfer only if the address in the control byte equals its strap pins.

The register map is: 0x00 direction (1 = input, reset value 0xFF), 0x01 read polarity invert, 0x02 interrupt enable, 0x03 compare value, 0x04 interrupt mode, 0x05 configuration, 0x06 pull-up, 0x07 interrupt flags, 0x08 captured levels, 0x09 pin levels, 0x0A output latch. The interrupt logic is a separate neighbour. The neighbour takes registers 0x02 to 0x05 as outputs and supplies the read-only contents of 0x07 and 0x08. Configuration bit 5 (set = hold the pointer) and bit 3 (set = address matching) are decoded here. All SPI inputs and the pin inputs pass through synchronisers into the system clock, which must run at least eight times faster than the serial clock.

The transfer controller is a state machine with six states. IDLE waits for the select to go low and moves to CTRL. CTRL receives the control byte: a hit moves to ADDR and a miss moves to IGNORE. ADDR loads the register pointer and moves to WRITE or READ according to the direction flag. WRITE stores each byte at the pointer, and READ shifts out the byte at the pointer. Both stay in place, advancing the pointer after each byte. IGNORE keeps the device silent. From any state, a high select returns the machine to IDLE.

Top module: `gpx_spi_expander`

## Requirements
- R1: After reset the direction register is 0xFF, so every pad output enable is 0. The output latch, pull-ups, interrupt-config outputs and configuration are 0, and the serial output enable is 0.
- R2: A control byte whose upper four bits are not `0100` makes the device ignore the whole transfer: no register changes and the serial output enable stays 0.
- R3: A write transfer (control bit 0 = 0, then address, then data) stores the data byte in the addressed register. The pad output enable of each pin is the inverse of its direction bit (direction 1 = input).
- R4: The pad outputs follow the output latch at 0x0A. Writing 0x09 also loads the output latch.
- R5: A read transfer (control bit 0 = 1) returns, MSB first, the addressed register. Register 0x09 returns the synchronised pin levels XOR the polarity register 0x01. Registers 0x00 to 0x06 and 0x0A return their stored values.
- R6: Read data changes only after a falling serial clock edge. The serial output enable is 1 only during the data bytes of a selected read, never during the control or address byte, and it falls once the select goes high.
- R7: With configuration bit 5 clear, the pointer advances after every data byte of a burst. It wraps from 0x0A, or from any higher address, to 0x00.
- R8: With configuration bit 5 set, every data byte of a burst accesses the same register.
- R9: With configuration bit 3 clear, any device address is accepted. With it set, a transfer whose address bits 3:1 differ from the strap pins writes nothing and leaves the serial output enable at 0.
- R10: Addresses 0x0B to 0xFF read as 0x00, and writes to them change nothing.
- R11: Registers 0x07 and 0x08 read the flag and capture inputs from the interrupt neighbour, and writes to them change nothing.
- R12: Registers 0x02, 0x03, 0x04 and 0x05 drive the interrupt-enable, compare, mode and configuration outputs.
- R13: Raising the select in the middle of a byte discards the partial byte. The next transfer starts cleanly with a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso (0 = high impedance) |
| hw_addr_i | input | 3 | Device address strap pins |
| pad_in | input | 8 | Pin levels seen at the pads |
| pad_out | output | 8 | Output latch value to the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pullup | output | 8 | Per-pin pull-up enable |
| irq_flag_i | input | 8 | Interrupt flags from the interrupt block |
| irq_cap_i | input | 8 | Captured levels from the interrupt block |
| irq_en_o | output | 8 | Interrupt enable register |
| irq_defval_o | output | 8 | Compare value register |
| irq_ctl_o | output | 8 | Interrupt mode register |
| cfg_o | output | 8 | Configuration register |

## Verification
The embedded properties check several rules on every cycle. Serial output holds between detected falling edges, and the output enable follows the select. An ignored transfer never writes and never drives. The pointer wraps at the last register or holds in hold mode, and writes to read-only or unmapped addresses leave every register unchanged. Only the bench's transfer scenarios can show the rest, checked against a behavioural register model: that bursts cross the right registers in order, that the polarity mix on port reads is correct, that prefix and address filtering decide correctly, and that an aborted byte leaves no trace.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W      = 8;
    localparam int BIT_CNT_W   = $clog2(BYTE_W);
    localparam int HW_ADDR_W   = 3;
    localparam int PREFIX_W    = BYTE_W - HW_ADDR_W - 1;
    localparam logic [PREFIX_W-1:0] CTRL_PREFIX = 4'b0100;

    localparam logic [7:0] REG_DIR  = 8'h00;
    localparam logic [7:0] REG_POL  = 8'h01;
    localparam logic [7:0] REG_IEN  = 8'h02;
    localparam logic [7:0] REG_DEF  = 8'h03;
    localparam logic [7:0] REG_ICT  = 8'h04;
    localparam logic [7:0] REG_CFG  = 8'h05;
    localparam logic [7:0] REG_PUP  = 8'h06;
    localparam logic [7:0] REG_FLG  = 8'h07;
    localparam logic [7:0] REG_CAP  = 8'h08;
    localparam logic [7:0] REG_PORT = 8'h09;
    localparam logic [7:0] REG_LAT  = 8'h0A;
    localparam logic [7:0] REG_LAST = REG_LAT;

    localparam int CFG_SEQ_DIS_BIT = 5;
    localparam int CFG_ADDR_EN_BIT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } xfer_state_t;
endpackage

// File: rtl/gpx_bit_sync.sv
module gpx_bit_sync #(
    parameter int               WIDTH = 1,
    parameter int               DEPTH = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= INIT;
                else        stage[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= INIT;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/gpx_spi_shifter.sv
module gpx_spi_shifter
    import gpx_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              cs_idle,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    logic [2:0]           sync_q;
    logic                 sclk_s, mosi_s;
    logic                 sclk_prev;
    logic                 rise, fall;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    rx_sh;
    logic [BYTE_W-1:0]    tx_sh;

    gpx_bit_sync #(.WIDTH(3), .DEPTH(SYNC_DEPTH), .INIT(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sclk, spi_cs_n, spi_mosi}),
        .q     (sync_q)
    );

    assign sclk_s  = sync_q[2];
    assign cs_idle = sync_q[1];
    assign mosi_s  = sync_q[0];
    assign rise    = sclk_s & ~sclk_prev;
    assign fall    = ~sclk_s & sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else if (cs_idle) begin
            bit_cnt  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    rx_byte  <= {rx_sh[BYTE_W-2:0], mosi_s};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            miso  <= 1'b0;
        end else if (cs_idle) begin
            miso  <= 1'b0;
        end else if (fall) begin
            if (bit_cnt == '0) begin
                miso  <= tx_byte[BYTE_W-1];
                tx_sh <= {tx_byte[BYTE_W-2:0], 1'b0};
            end else begin
                miso  <= tx_sh[BYTE_W-1];
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // R6: serial output only moves after a detected falling clock edge
    assert_miso_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_idle) |=> $stable(miso));
endmodule

// File: rtl/gpx_xfer_ctrl.sv
module gpx_xfer_ctrl
    import gpx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_idle,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic [HW_ADDR_W-1:0] hw_addr,
    input  logic                 addr_en,
    input  logic                 seq_dis,
    output logic                 wr_en,
    output logic [7:0]           reg_ptr,
    output logic                 miso_oe
);
    xfer_state_t state_q, state_d;
    logic        rd_q;
    logic        ctrl_hit;
    logic        data_byte;
    logic [7:0]  ptr_next;

    assign ctrl_hit = (rx_byte[BYTE_W-1:HW_ADDR_W+1] == CTRL_PREFIX) &&
                      (!addr_en || (rx_byte[HW_ADDR_W:1] == hw_addr));
    assign data_byte = rx_valid && !cs_idle &&
                       ((state_q == ST_WRITE) || (state_q == ST_READ));
    assign ptr_next  = (reg_ptr >= REG_LAST) ? 8'h00 : reg_ptr + 8'h01;
    assign wr_en     = (state_q == ST_WRITE) && rx_valid && !cs_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cs_idle) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_CTRL;
                ST_CTRL:   if (rx_valid) state_d = ctrl_hit ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (rx_valid) state_d = rd_q ? ST_READ : ST_WRITE;
                ST_WRITE:  state_d = ST_WRITE;
                ST_READ:   state_d = ST_READ;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            reg_ptr <= 8'h00;
            miso_oe <= 1'b0;
        end else begin
            miso_oe <= (state_d == ST_READ);
            if ((state_q == ST_CTRL) && rx_valid)
                rd_q <= rx_byte[0];
            if ((state_q == ST_ADDR) && rx_valid && !cs_idle)
                reg_ptr <= rx_byte;
            else if (data_byte && !seq_dis)
                reg_ptr <= ptr_next;
        end
    end

    // R7: the pointer returns to the first register after the last one
    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && !seq_dis && (reg_ptr == REG_LAST)) |=> (reg_ptr == 8'h00));

    // R8: hold mode keeps the pointer on one register
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && seq_dis) |=> $stable(reg_ptr));

    // R9: an ignored transfer neither writes nor drives
    assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> (!wr_en && !miso_oe));

    // R6: drive enable only while the select was low
    assert_oe_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> $past(!cs_idle));
endmodule

// File: rtl/gpx_reg_file.sv
module gpx_reg_file
    import gpx_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        ptr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] pad_in,
    input  logic [BYTE_W-1:0] irq_flag_i,
    input  logic [BYTE_W-1:0] irq_cap_i,
    output logic [BYTE_W-1:0] pad_out,
    output logic [BYTE_W-1:0] pad_oe,
    output logic [BYTE_W-1:0] pad_pullup,
    output logic [BYTE_W-1:0] irq_en_o,
    output logic [BYTE_W-1:0] irq_defval_o,
    output logic [BYTE_W-1:0] irq_ctl_o,
    output logic [BYTE_W-1:0] cfg_o,
    output logic              addr_en,
    output logic              seq_dis
);
    logic [BYTE_W-1:0] dir_q, pol_q, ien_q, def_q, ict_q, cfg_q, pup_q, lat_q;
    logic [BYTE_W-1:0] pin_s;

    gpx_bit_sync #(.WIDTH(BYTE_W), .DEPTH(SYNC_DEPTH), .INIT('0)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            pol_q <= '0;
            ien_q <= '0;
            def_q <= '0;
            ict_q <= '0;
            cfg_q <= '0;
            pup_q <= '0;
            lat_q <= '0;
        end else if (wr_en) begin
            case (ptr)
                REG_DIR:  dir_q <= wr_data;
                REG_POL:  pol_q <= wr_data;
                REG_IEN:  ien_q <= wr_data;
                REG_DEF:  def_q <= wr_data;
                REG_ICT:  ict_q <= wr_data;
                REG_CFG:  cfg_q <= wr_data;
                REG_PUP:  pup_q <= wr_data;
                REG_PORT: lat_q <= wr_data;
                REG_LAT:  lat_q <= wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (ptr)
            REG_DIR:  rd_data = dir_q;
            REG_POL:  rd_data = pol_q;
            REG_IEN:  rd_data = ien_q;
            REG_DEF:  rd_data = def_q;
            REG_ICT:  rd_data = ict_q;
            REG_CFG:  rd_data = cfg_q;
            REG_PUP:  rd_data = pup_q;
            REG_FLG:  rd_data = irq_flag_i;
            REG_CAP:  rd_data = irq_cap_i;
            REG_PORT: rd_data = pin_s ^ pol_q;
            REG_LAT:  rd_data = lat_q;
            default:  rd_data = '0;
        endcase
    end

    for (genvar p = 0; p < BYTE_W; p++) begin : g_pin
        assign pad_oe[p]     = ~dir_q[p];
        assign pad_out[p]    = lat_q[p];
        assign pad_pullup[p] = pup_q[p];
    end

    assign irq_en_o     = ien_q;
    assign irq_defval_o = def_q;
    assign irq_ctl_o    = ict_q;
    assign cfg_o        = cfg_q;
    assign addr_en      = cfg_q[CFG_ADDR_EN_BIT];
    assign seq_dis      = cfg_q[CFG_SEQ_DIS_BIT];

    // R10: writes beyond the map leave every register untouched
    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ptr > REG_LAST)) |=>
        ($stable(dir_q) && $stable(pol_q) && $stable(ien_q) && $stable(def_q) &&
         $stable(ict_q) && $stable(cfg_q) && $stable(pup_q) && $stable(lat_q)));

    // R11: writes to flag and capture addresses change nothing
    assert_readonly_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((ptr == REG_FLG) || (ptr == REG_CAP))) |=>
        ($stable(dir_q) && $stable(pol_q) && $stable(ien_q) && $stable(def_q) &&
         $stable(ict_q) && $stable(cfg_q) && $stable(pup_q) && $stable(lat_q)));
endmodule

// File: rtl/gpx_spi_expander.sv
module gpx_spi_expander
    import gpx_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sclk,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    output logic                 spi_miso_oe,
    input  logic [HW_ADDR_W-1:0] hw_addr_i,
    input  logic [BYTE_W-1:0]    pad_in,
    output logic [BYTE_W-1:0]    pad_out,
    output logic [BYTE_W-1:0]    pad_oe,
    output logic [BYTE_W-1:0]    pad_pullup,
    input  logic [BYTE_W-1:0]    irq_flag_i,
    input  logic [BYTE_W-1:0]    irq_cap_i,
    output logic [BYTE_W-1:0]    irq_en_o,
    output logic [BYTE_W-1:0]    irq_defval_o,
    output logic [BYTE_W-1:0]    irq_ctl_o,
    output logic [BYTE_W-1:0]    cfg_o
);
    logic              cs_idle, rx_valid, wr_en, addr_en, seq_dis;
    logic [BYTE_W-1:0] rx_byte, rd_data;
    logic [7:0]        reg_ptr;

    gpx_spi_shifter #(.SYNC_DEPTH(SYNC_DEPTH)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .tx_byte  (rd_data),
        .cs_idle  (cs_idle),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .miso     (spi_miso)
    );

    gpx_xfer_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_idle  (cs_idle),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .hw_addr  (hw_addr_i),
        .addr_en  (addr_en),
        .seq_dis  (seq_dis),
        .wr_en    (wr_en),
        .reg_ptr  (reg_ptr),
        .miso_oe  (spi_miso_oe)
    );

    gpx_reg_file #(.SYNC_DEPTH(SYNC_DEPTH)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .ptr          (reg_ptr),
        .wr_data      (rx_byte),
        .rd_data      (rd_data),
        .pad_in       (pad_in),
        .irq_flag_i   (irq_flag_i),
        .irq_cap_i    (irq_cap_i),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pad_pullup   (pad_pullup),
        .irq_en_o     (irq_en_o),
        .irq_defval_o (irq_defval_o),
        .irq_ctl_o    (irq_ctl_o),
        .cfg_o        (cfg_o),
        .addr_en      (addr_en),
        .seq_dis      (seq_dis)
    );
endmodule

// File: tb/gpx_spi_expander_bench.sv
module gpx_spi_expander_bench;
    localparam int H = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe;
    logic [2:0] hw_addr_i = 3'd5;
    logic [7:0] pad_in = 8'h00, irq_flag_i = 8'h00, irq_cap_i = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pullup, irq_en_o, irq_defval_o, irq_ctl_o, cfg_o;

    gpx_spi_expander u_gpx_spi_expander (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .hw_addr_i(hw_addr_i), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pullup(pad_pullup), .irq_flag_i(irq_flag_i), .irq_cap_i(irq_cap_i),
        .irq_en_o(irq_en_o), .irq_defval_o(irq_defval_o), .irq_ctl_o(irq_ctl_o),
        .cfg_o(cfg_o)
    );

    int   vectors = 0, miscompares = 0;
    bit   busy = 1'b1, done = 1'b0, oe_seen = 1'b0;
    logic [7:0] m_reg [0:10];
    logic [7:0] wbuf [16];

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'h07) return irq_flag_i;
        if (a == 8'h08) return irq_cap_i;
        if (a == 8'h09) return pad_in ^ m_reg[1];
        if (a <= 8'h0A) return m_reg[a[3:0]];
        return 8'h00;
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h09) m_reg[10] = d;
        else if (a <= 8'h0A && a != 8'h07 && a != 8'h08) m_reg[a[3:0]] = d;
    endtask

    function automatic logic [7:0] cw(input logic [2:0] a, input bit rd);
        return {4'b0100, a, rd};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // model compared against the outputs on every clock outside transfers
    always @(negedge clk) begin
        if (!busy && rst_n && !done) begin
            chk("R3", "pad_oe", pad_oe, ~m_reg[0]);
            chk("R4", "pad_out", pad_out, m_reg[10]);
            chk("R3", "pad_pullup", pad_pullup, m_reg[6]);
            chk("R12", "irq_en_o", irq_en_o, m_reg[2]);
            chk("R12", "irq_defval_o", irq_defval_o, m_reg[3]);
            chk("R12", "irq_ctl_o", irq_ctl_o, m_reg[4]);
            chk("R12", "cfg_o", cfg_o, m_reg[5]);
            chk("R6", "idle miso_oe", {7'd0, spi_miso_oe}, 8'h00);
        end
        if (!spi_cs_n && spi_miso_oe) oe_seen = 1'b1;
    end

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] oeb);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            wait_clk(H);
            spi_sclk = 1'b1;
            rx[i]  = spi_miso;
            oeb[i] = spi_miso_oe;
            wait_clk(H);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic xact(input string req, input logic [7:0] ctrl, input logic [7:0] addr, input int n);
        logic [7:0] rx, oeb, ptr, exp;
        bit sel, rd, hold;
        busy = 1'b1; oe_seen = 1'b0;
        spi_cs_n = 1'b0;
        wait_clk(H);
        sel = (ctrl[7:4] == 4'b0100) && (!m_reg[5][3] || ctrl[3:1] == hw_addr_i);
        rd  = ctrl[0];
        spi_byte(ctrl, rx, oeb);
        chk("R6", {req, " oe in control byte"}, oeb, 8'h00);
        spi_byte(addr, rx, oeb);
        chk("R6", {req, " oe in address byte"}, oeb, 8'h00);
        ptr = addr;
        for (int k = 0; k < n; k++) begin
            hold = m_reg[5][5];
            if (rd) begin
                exp = m_read(ptr);
                spi_byte(8'h00, rx, oeb);
                if (sel) begin
                    chk(req, $sformatf("read byte %0d at %h", k, ptr), rx, exp);
                    chk("R6", {req, " oe in data"}, oeb, 8'hFF);
                end
            end else begin
                spi_byte(wbuf[k], rx, oeb);
                if (sel) m_write(ptr, wbuf[k]);
            end
            if (sel && !hold) ptr = (ptr >= 8'h0A) ? 8'h00 : ptr + 8'h01;
        end
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(6);
        if (!sel) chk(req, "ignored transfer drove miso", {7'd0, oe_seen}, 8'h00);
        busy = 1'b0;
        wait_clk(2);
    endtask

    task automatic wr1(input string req, input logic [7:0] a, input logic [7:0] d);
        wbuf[0] = d;
        xact(req, cw(3'd0, 1'b0), a, 1);
    endtask

    task automatic rd_n(input string req, input logic [7:0] a, input int n);
        xact(req, cw(3'd0, 1'b1), a, n);
    endtask

    initial begin
        for (int i = 0; i <= 10; i++) m_reg[i] = 8'h00;
        m_reg[0] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1", "reset pad_oe", pad_oe, 8'h00);
        chk("R1", "reset pad_out", pad_out, 8'h00);
        chk("R1", "reset pullup", pad_pullup, 8'h00);
        chk("R1", "reset cfg", cfg_o, 8'h00);
        chk("R1", "reset miso_oe", {7'd0, spi_miso_oe}, 8'h00);
        busy = 1'b0;
        wait_clk(4);

        // R3 R4 R9: plain writes with matching off and a foreign address
        wr1("R3", 8'h00, 8'hF0);
        wr1("R4", 8'h0A, 8'h5A);
        rd_n("R5", 8'h00, 1);
        rd_n("R5", 8'h0A, 1);
        wbuf[0] = 8'h3C;
        xact("R9", cw(3'd2, 1'b0), 8'h06, 1);

        // R5: port read with polarity mix
        pad_in = 8'hC3;
        wr1("R5", 8'h01, 8'h0F);
        rd_n("R5", 8'h09, 1);

        // R7: burst write across registers, burst read wrapping past 0x0A
        wbuf[0] = 8'h00; wbuf[1] = 8'hFF; wbuf[2] = 8'h81; wbuf[3] = 8'h42;
        xact("R7", cw(3'd0, 1'b0), 8'h00, 4);
        rd_n("R7", 8'h09, 4);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        xact("R7", cw(3'd0, 1'b0), 8'h0A, 2);
        rd_n("R7", 8'h00, 11);

        // R4: writing the port register loads the latch
        wr1("R4", 8'h09, 8'hA6);
        rd_n("R4", 8'h0A, 1);

        // R10: unmapped addresses
        wr1("R10", 8'h0C, 8'h99);
        rd_n("R10", 8'h0C, 1);
        rd_n("R10", 8'hFF, 1);
        rd_n("R10", 8'h0B, 2);

        // R11: read-only flag and capture registers
        irq_flag_i = 8'hA5; irq_cap_i = 8'h3C;
        rd_n("R11", 8'h07, 2);
        wr1("R11", 8'h07, 8'h00);
        wr1("R11", 8'h08, 8'hFF);
        rd_n("R11", 8'h07, 2);

        // R12: interrupt configuration outputs
        wbuf[0] = 8'h0F; wbuf[1] = 8'hF0; wbuf[2] = 8'h55;
        xact("R12", cw(3'd0, 1'b0), 8'h02, 3);

        // R8: hold mode
        wr1("R8", 8'h05, 8'h20);
        rd_n("R8", 8'h0A, 3);
        wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
        xact("R8", cw(3'd0, 1'b0), 8'h06, 3);
        rd_n("R8", 8'h06, 2);

        // R9: address matching on, straps = 5
        wr1("R9", 8'h05, 8'h08);
        wbuf[0] = 8'hEE;
        xact("R9", cw(3'd2, 1'b0), 8'h0A, 1);
        xact("R9", cw(3'd2, 1'b1), 8'h00, 2);
        wbuf[0] = 8'h77;
        xact("R9", cw(3'd5, 1'b0), 8'h0A, 1);
        xact("R9", cw(3'd5, 1'b1), 8'h0A, 1);

        // R2: wrong prefix with matching address bits
        wbuf[0] = 8'h00;
        xact("R2", 8'h5A, 8'h0A, 1);
        xact("R2", 8'hCB, 8'h0A, 1);

        // R13: abort in the middle of a data byte
        begin
            logic [7:0] rx, oeb;
            busy = 1'b1;
            spi_cs_n = 1'b0;
            wait_clk(H);
            spi_byte(cw(3'd5, 1'b0), rx, oeb);
            spi_byte(8'h0A, rx, oeb);
            for (int i = 0; i < 4; i++) begin
                spi_mosi = 1'b1; wait_clk(H);
                spi_sclk = 1'b1; wait_clk(H);
                spi_sclk = 1'b0;
            end
            wait_clk(H);
            spi_cs_n = 1'b1;
            wait_clk(8);
            chk("R13", "latch after aborted byte", pad_out, m_reg[10]);
            busy = 1'b0;
            wait_clk(2);
        end
        wbuf[0] = 8'h3E;
        xact("R13", cw(3'd5, 1'b0), 8'h0A, 1);
        xact("R13", cw(3'd5, 1'b1), 8'h0A, 1);

        wait_clk(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule